// File: doc/BRIEF.md
# Slice-Granular Bit-Stream Reorderer

This block reorders a data word in fixed-size groups of bits ("slices") with one register stage of latency. In left-stream mode the word is cut into slices starting at its least significant bit, and the slice order is reversed while the bits inside each slice keep their order. The slice size is chosen at run time. In right-stream mode the word passes through unchanged. A request that carries an illegal slice size raises an error flag in place of a result.

An unpack mode takes a source that is up to `EXT` bits wider than the destination. The whole source is reordered, and the most significant `WIDTH` bits of the reordered value are kept. Power-of-two slice sizes can be served by a shift-and-swap network that the parameter `USE_FAST` selects. This network must agree bit for bit with the general slice walk.

Top module: `slice_stream_reorder`

## Requirements
- R1: A legal request (`in_valid`=1) produces `out_data` and a one-cycle `out_valid` pulse on the clock edge that follows. In a cycle with no request, `out_valid` and `out_err` are low one edge later.
- R2: With `in_left`=1, slice k holds input bits [k*S, k*S+S-1], where S is `in_slice`. Slice 0 lands at the top of the output and each later slice sits directly below the previous one. Bit order inside a slice is kept, so S=1 gives a full reversal (4-bit 0001 gives 1000).
- R3: When S does not divide the source length, the short top slice lands at the least significant end of the output. 11-bit 0x497 with S=4 gives 0x3CC, and 32-bit 0xD70A4497 with S=3 gives 0xE92910EB.
- R4: A slice size equal to or larger than the source length returns the source unchanged. 4-bit 0001 with S=4 or S=5 gives 0001.
- R5: With `in_left`=0, the output equals the source for every nonzero slice size.
- R6: `in_slice`=0 is illegal. One edge later `out_err` is 1, `out_valid` is 0, and `out_data` keeps its previous value.
- R7: With `in_unpack`=1, the source is `in_data[WIDTH+E-1:0]`, where E=`in_extra`. The source is reordered over its full length, and the top `WIDTH` bits of the result are output. 5-bit 01101 into 4 bits gives 0110 in right-stream mode and in left-stream mode with S=5. E greater than `EXT` is illegal and is handled as in R6.
- R8: Left-stream is not its own inverse. Applying S=3 to 4-bit 0001 gives 0010, and applying S=3 to that result gives 0100.
- R9: For power-of-two slice sizes, the fast network's result equals the general slice walk's result.
- R10: A source of all ones yields an output of all ones for every slice size.
- R11: A synchronous active-high `rst` clears `out_data`, `out_valid` and `out_err`.
- R12: Bits of `in_data` above the source length have no effect on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | WIDTH+EXT | Source word, least significant bits used |
| in_slice | input | clog2(WIDTH+EXT+1) | Slice size in bits; 0 is illegal |
| in_left | input | 1 | 1 = left-stream (reorder), 0 = right-stream (pass) |
| in_unpack | input | 1 | 1 = source is WIDTH+in_extra bits, top WIDTH kept |
| in_extra | input | clog2(EXT+1) | Extra source bits in unpack mode |
| out_data | output | WIDTH | Registered result |
| out_valid | output | 1 | Result strobe, one cycle after a legal request |
| out_err | output | 1 | Illegal-request strobe, one cycle after the request |

## Verification
Every result, valid pulse and error pulse is due on the first rising edge after the request. The bench drives each request on a falling edge, lets exactly one rising edge pass, and reads the outputs at the following falling edge. Holding behaviour is checked after an idle cycle, where `out_valid` must have dropped while `out_data` stays put. An illegal request is checked in the same way: one edge later the error flag must be high and the earlier result still present.

// File: rtl/stream_pkg.sv
package stream_pkg;

    // Direction select on in_left
    typedef enum logic {
        STREAM_RIGHT = 1'b0,
        STREAM_LEFT  = 1'b1
    } stream_dir_e;

    // Which datapath produces the reordered word
    typedef enum logic [1:0] {
        PATH_PASS    = 2'd0,
        PATH_GENERAL = 2'd1,
        PATH_FAST    = 2'd2
    } stream_path_e;

    // Decoded request
    typedef struct packed {
        logic         take;   // legal request, load result
        logic         flag;   // illegal request, raise error
        stream_path_e path;
    } stream_ctl_t;

    // Exponent of the power of two that covers n (at least 1)
    function automatic int cover_log2(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/stream_req_decode.sv
module stream_req_decode
    import stream_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int EXT      = 8,
    parameter bit USE_FAST = 1'b1,
    parameter int SZW      = 5,
    parameter int EW       = 4,
    parameter int LW       = 5,
    parameter int GW       = 3
) (
    input  logic              in_valid,
    input  logic [SZW-1:0]    in_slice,
    input  logic              in_left,
    input  logic              in_unpack,
    input  logic [EW-1:0]     in_extra,
    output stream_ctl_t       ctl,
    output logic [LW-1:0]     eff_len,
    output logic [EW-1:0]     drop,
    output logic [GW-1:0]     slice_log2
);

    logic size_ok;
    logic extra_ok;
    logic is_pow2;
    logic fits;

    always_comb begin
        size_ok  = (in_slice != '0);
        extra_ok = !in_unpack || (int'(in_extra) <= EXT);
        drop     = in_unpack ? in_extra : '0;
        eff_len  = LW'(WIDTH) + LW'(drop);
        is_pow2  = $onehot(in_slice);
        fits     = (int'(in_slice) <= int'(eff_len));

        slice_log2 = '0;
        for (int b = 0; b < SZW; b++) begin
            if (in_slice[b]) slice_log2 = GW'(b);
        end

        ctl.take = in_valid && size_ok && extra_ok;
        ctl.flag = in_valid && !(size_ok && extra_ok);
        if (stream_dir_e'(in_left) == STREAM_RIGHT) begin
            ctl.path = PATH_PASS;
        end else if (USE_FAST && is_pow2 && fits) begin
            ctl.path = PATH_FAST;
        end else begin
            ctl.path = PATH_GENERAL;
        end
    end

endmodule

// File: rtl/slice_stream_general.sv
module slice_stream_general #(
    parameter int MAXL = 24,
    parameter int SZW  = 5,
    parameter int LW   = 5
) (
    input  logic [MAXL-1:0] src,
    input  logic [LW-1:0]   len,
    input  logic [SZW-1:0]  size,
    output logic [MAXL-1:0] res
);

    localparam int IW = (MAXL > 2) ? $clog2(MAXL) : 1;

    int seg;
    int pos;
    int n;
    int s;

    // Walk the source upward; seg marks where the current slice begins.
    always_comb begin
        res = '0;
        seg = 0;
        pos = 0;
        n   = int'(len);
        s   = int'(size);
        for (int i = 0; i < MAXL; i++) begin
            if (i < n) begin
                if ((i - seg) == s) seg = i;
                pos = n - seg - s;
                if (pos < 0) pos = 0;
                res[IW'(pos + i - seg)] = src[IW'(i)];
            end
        end
    end

endmodule

// File: rtl/slice_stream_pow2.sv
module slice_stream_pow2
    import stream_pkg::*;
#(
    parameter int MAXL = 24,
    parameter int LW   = 5,
    parameter int GW   = 3
) (
    input  logic [MAXL-1:0] src,
    input  logic [LW-1:0]   len,
    input  logic [GW-1:0]   lg,
    output logic [MAXL-1:0] res
);

    localparam int PL = cover_log2(MAXL);
    localparam int P  = 1 << PL;

    typedef logic [P-1:0] word_t;

    // Bits whose block index (block size 2**t) is even
    function automatic word_t even_blocks(input int t);
        word_t m;
        for (int j = 0; j < P; j++) m[j] = (((j >> t) & 1) == 0);
        return m;
    endfunction

    word_t pre;
    word_t stage [PL+1];

    int n;
    int s;
    int floor_len;
    int rem;
    word_t keep;
    word_t top;

    // Lift the short top slice so that it fills its whole slot
    always_comb begin
        n         = int'(len);
        s         = 1 << int'(lg);
        floor_len = n & ~(s - 1);
        rem       = n - floor_len;
        keep      = (word_t'(1) << n) - word_t'(1);
        pre       = word_t'(src) & keep;
        top       = ((word_t'(1) << rem) - word_t'(1)) << floor_len;
        if (rem != 0) begin
            pre = (pre & ~top) | ((pre & top) << (s - rem));
        end
    end

    assign stage[0] = pre;

    // Swap stages run from block size 2**lg up to P/2
    for (genvar t = 0; t < PL; t++) begin : g_swap
        localparam word_t M = even_blocks(t);
        assign stage[t+1] = (int'(lg) <= t)
            ? (((stage[t] >> (1 << t)) & M) | ((stage[t] & M) << (1 << t)))
            : stage[t];
    end

    assign res = MAXL'(stage[PL] >> (P - n));

endmodule

// File: rtl/slice_stream_reorder.sv
module slice_stream_reorder
    import stream_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int EXT      = 8,
    parameter bit USE_FAST = 1'b1,
    localparam int MAXL    = WIDTH + EXT,
    localparam int SZW     = $clog2(MAXL + 1),
    localparam int EW      = $clog2(EXT + 1),
    localparam int LW      = $clog2(MAXL + 1),
    localparam int GW      = $clog2(cover_log2(MAXL) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [MAXL-1:0]  in_data,
    input  logic [SZW-1:0]   in_slice,
    input  logic             in_left,
    input  logic             in_unpack,
    input  logic [EW-1:0]    in_extra,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid,
    output logic             out_err
);

    stream_ctl_t     ctl;
    logic [LW-1:0]   eff_len;
    logic [EW-1:0]   drop;
    logic [GW-1:0]   slice_log2;
    logic [MAXL-1:0] gen_res;
    logic [MAXL-1:0] fast_res;
    logic [MAXL-1:0] picked;
    logic [WIDTH-1:0] next_data;

    stream_req_decode #(
        .WIDTH(WIDTH), .EXT(EXT), .USE_FAST(USE_FAST),
        .SZW(SZW), .EW(EW), .LW(LW), .GW(GW)
    ) u_decode (
        .in_valid  (in_valid),
        .in_slice  (in_slice),
        .in_left   (in_left),
        .in_unpack (in_unpack),
        .in_extra  (in_extra),
        .ctl       (ctl),
        .eff_len   (eff_len),
        .drop      (drop),
        .slice_log2(slice_log2)
    );

    slice_stream_general #(.MAXL(MAXL), .SZW(SZW), .LW(LW)) u_general (
        .src (in_data),
        .len (eff_len),
        .size(in_slice),
        .res (gen_res)
    );

    if (USE_FAST) begin : g_fast
        slice_stream_pow2 #(.MAXL(MAXL), .LW(LW), .GW(GW)) u_pow2 (
            .src(in_data),
            .len(eff_len),
            .lg (slice_log2),
            .res(fast_res)
        );

        AST_FAST_EQ_GENERAL: assert property (@(posedge clk) disable iff (rst)
            (ctl.path == PATH_FAST) |-> (fast_res == gen_res)) // R9
            else $error("fast network disagrees with slice walk");
    end else begin : g_nofast
        assign fast_res = gen_res;
    end

    always_comb begin
        unique case (ctl.path)
            PATH_FAST:    picked = fast_res;
            PATH_GENERAL: picked = gen_res;
            default:      picked = in_data;
        endcase
        next_data = WIDTH'(picked >> drop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= ctl.take;
            out_err   <= ctl.flag;
            if (ctl.take) out_data <= next_data;
        end
    end

    AST_LEGAL_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_slice != '0 && !in_unpack) |=> (out_valid && !out_err)) // R1
        else $error("legal request gave no result");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_err)) // R1
        else $error("strobe without request");

    AST_ZERO_SLICE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_slice == '0) |=> (out_err && !out_valid)) // R6
        else $error("zero slice not flagged");

    AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        out_err |-> $stable(out_data)) // R6
        else $error("illegal request changed data");

    AST_RIGHT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_left && !in_unpack && in_slice != '0)
        |=> (out_data == $past(in_data[WIDTH-1:0]))) // R5
        else $error("right-stream reordered data");

    AST_BIG_SLICE_SAME: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_unpack && int'(in_slice) >= WIDTH)
        |=> (out_data == $past(in_data[WIDTH-1:0]))) // R4
        else $error("oversize slice changed data");

    AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_unpack && in_slice != '0 && (&in_data[WIDTH-1:0]))
        |=> (&out_data)) // R10
        else $error("all-ones input lost a bit");

    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_err)) // R6
        else $error("valid and error together");

endmodule

// File: tb/test_slice_stream_reorder.sv
`timescale 1ns/1ps
module test_slice_stream_reorder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        s_valid = 1'b0;
    logic [39:0] s_data  = '0;
    logic [5:0]  s_slice = '0;
    logic        s_left  = 1'b0;
    logic        s_unp   = 1'b0;
    logic [3:0]  s_extra = '0;

    logic [15:0] o16; logic v16, e16;
    logic [3:0]  o4;  logic v4,  e4;
    logic [10:0] o11; logic v11, e11;
    logic [31:0] o32; logic v32, e32;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    slice_stream_reorder i_slice_stream_reorder (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_data(s_data[23:0]),
        .in_slice(s_slice[4:0]), .in_left(s_left), .in_unpack(s_unp),
        .in_extra(s_extra), .out_data(o16), .out_valid(v16), .out_err(e16));

    slice_stream_reorder #(.WIDTH(4)) u_w4 (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_data(s_data[11:0]),
        .in_slice(s_slice[3:0]), .in_left(s_left), .in_unpack(s_unp),
        .in_extra(s_extra), .out_data(o4), .out_valid(v4), .out_err(e4));

    slice_stream_reorder #(.WIDTH(11)) u_w11 (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_data(s_data[18:0]),
        .in_slice(s_slice[4:0]), .in_left(s_left), .in_unpack(s_unp),
        .in_extra(s_extra), .out_data(o11), .out_valid(v11), .out_err(e11));

    slice_stream_reorder #(.WIDTH(32)) u_w32 (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_data(s_data[39:0]),
        .in_slice(s_slice[5:0]), .in_left(s_left), .in_unpack(s_unp),
        .in_extra(s_extra), .out_data(o32), .out_valid(v32), .out_err(e32));

    // inst: 0 = 16-bit, 1 = 4-bit, 2 = 11-bit, 3 = 32-bit
    typedef struct packed {
        logic [1:0]  inst;
        logic [39:0] data;
        logic [5:0]  slice;
        logic        left;
        logic        unp;
        logic [3:0]  extra;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 40'h1,        6'd1, 1'b1, 1'b0, 4'd0, 32'h8},        // R2 full reversal
        '{2'd1, 40'h1,        6'd2, 1'b1, 1'b0, 4'd0, 32'h4},        // R2
        '{2'd1, 40'h1,        6'd3, 1'b1, 1'b0, 4'd0, 32'h2},        // R3 short top slice
        '{2'd1, 40'h1,        6'd4, 1'b1, 1'b0, 4'd0, 32'h1},        // R4
        '{2'd1, 40'h1,        6'd5, 1'b1, 1'b0, 4'd0, 32'h1},        // R4
        '{2'd1, 40'h1,        6'd3, 1'b0, 1'b0, 4'd0, 32'h1},        // R5
        '{2'd2, 40'h497,      6'd4, 1'b1, 1'b0, 4'd0, 32'h3CC},      // R3
        '{2'd3, 40'hD70A4497, 6'd3, 1'b1, 1'b0, 4'd0, 32'hE92910EB}, // R3
        '{2'd3, 40'h04030201, 6'd1, 1'b1, 1'b0, 4'd0, 32'h8040C020}, // R2
        '{2'd1, 40'h0D,       6'd5, 1'b1, 1'b1, 4'd1, 32'h6},        // R7
        '{2'd1, 40'h0D,       6'd1, 1'b0, 1'b1, 4'd1, 32'h6},        // R7
        '{2'd1, 40'h0D,       6'd1, 1'b1, 1'b1, 4'd1, 32'hB},        // R7
        '{2'd1, 40'h0D,       6'd2, 1'b1, 1'b1, 4'd1, 32'h7},        // R7
        '{2'd2, 40'h7FF,      6'd3, 1'b1, 1'b0, 4'd0, 32'h7FF},      // R10
        '{2'd1, 40'hFF1,      6'd1, 1'b1, 1'b0, 4'd0, 32'h8},        // R12 upper bits ignored
        '{2'd0, 40'hABCD,     6'd8, 1'b1, 1'b0, 4'd0, 32'hCDAB}      // R9 power-of-two slice
    };

    function automatic logic [63:0] got_data(input int inst);
        case (inst)
            0: return 64'(o16);
            1: return 64'(o4);
            2: return 64'(o11);
            default: return 64'(o32);
        endcase
    endfunction

    function automatic logic got_valid(input int inst);
        case (inst)
            0: return v16;
            1: return v4;
            2: return v11;
            default: return v32;
        endcase
    endfunction

    // Reference: append slices from the LSB upward onto a growing word
    function automatic logic [63:0] ref_stream(input logic [39:0] src, input int w,
                                               input int s, input bit left,
                                               input bit unp, input int extra);
        int len;
        int at;
        int sz;
        logic [63:0] m;
        logic [63:0] r;
        len = w + (unp ? extra : 0);
        m   = (64'(1) << len) - 64'(1);
        r   = 64'(src) & m;
        if (left) begin
            logic [63:0] acc;
            acc = '0;
            at  = 0;
            while (at < len) begin
                sz  = (len - at < s) ? (len - at) : s;
                acc = (acc << sz) | ((r >> at) & ((64'(1) << sz) - 64'(1)));
                at  = at + sz;
            end
            r = acc;
        end
        return (r >> (len - w)) & ((64'(1) << w) - 64'(1));
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [39:0] d, input int s, input bit left,
                         input bit unp, input int extra);
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = d;
        s_slice = 6'(s);
        s_left  = left;
        s_unp   = unp;
        s_extra = 4'(extra);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        logic [63:0] expv;
        lfsr = 32'hACE1_2357;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 data", 64'(o16), 64'h0);
        chk("R11 valid", 64'(v16), 64'h0);
        chk("R11 err", 64'(e16), 64'h0);

        // Table of vectors
        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].data, int'(VECS[k].slice), VECS[k].left, VECS[k].unp,
                  int'(VECS[k].extra));
            chk($sformatf("table %0d valid", k), 64'(got_valid(int'(VECS[k].inst))), 64'h1);
            chk($sformatf("table %0d data", k), got_data(int'(VECS[k].inst)), 64'(VECS[k].exp));
        end

        // R1 latency and idle drop
        issue(40'h1234, 4, 1'b1, 1'b0, 0);
        chk("R1 valid pulse", 64'(v16), 64'h1);
        chk("R1 result", 64'(o16), 64'h4321);
        @(negedge clk);
        chk("R1 idle valid low", 64'(v16), 64'h0);
        chk("R1 idle data held", 64'(o16), 64'h4321);

        // R6 zero slice
        issue(40'hFFFF, 0, 1'b1, 1'b0, 0);
        chk("R6 err", 64'(e16), 64'h1);
        chk("R6 no valid", 64'(v16), 64'h0);
        chk("R6 data held", 64'(o16), 64'h4321);
        @(negedge clk);
        chk("R6 err is a pulse", 64'(e16), 64'h0);

        // R7 too many extra bits
        issue(40'h0F0F0, 3, 1'b1, 1'b1, 9);
        chk("R7 extra over limit err", 64'(e16), 64'h1);
        chk("R7 extra over limit data", 64'(o16), 64'h4321);

        // R8 applied twice is not the identity
        issue(40'h1, 3, 1'b1, 1'b0, 0);
        chk("R8 first pass", 64'(o4), 64'h2);
        issue(40'(o4), 3, 1'b1, 1'b0, 0);
        chk("R8 second pass", 64'(o4), 64'h4);

        // R10 all ones for every slice size
        for (int s = 1; s <= 16; s++) begin
            issue(40'hFFFF, s, 1'b1, 1'b0, 0);
            chk($sformatf("R10 slice %0d", s), 64'(o16), 64'hFFFF);
        end

        // R2 R9 pseudo-random sweep against the reference model
        for (int k = 0; k < 300; k++) begin
            int s;
            int ex;
            bit lf;
            bit up;
            logic [39:0] d;
            lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h0400_0007 : 32'h0);
            d    = {8'h5A, lfsr};
            s    = (k % 24) + 1;
            lf   = (k % 5) != 0;
            up   = lfsr[3];
            ex   = int'(lfsr[7:4]) % 9;
            issue(d, s, lf, up, ex);
            expv = ref_stream(d, 16, s, lf, up, ex);
            chk($sformatf("R9 sweep %0d slice %0d", k, s), 64'(o16), expv);
        end

        // R11 reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 data cleared", 64'(o16), 64'h0);
        chk("R11 valid cleared", 64'(v16), 64'h0);

        finish_run();
    end

endmodule